// File: doc/BRIEF.md
# Tower-Field AES Forward Substitution Layer

This block performs the AES forward byte substitution on a full 128-bit state in one combinational pass. It uses no lookup table. Each of the sixteen byte lanes carries its byte into a three-level tower field, GF(((2^2)^2)^2), through a fixed linear change of basis. There it inverts the byte using only AND and XOR logic, maps the result back to the standard AES polynomial basis, and applies the AES affine transform.

The tower is built from three quadratic extensions:
- GF(2^2) uses w^2 = w + 1.
- GF(2^4) uses z^2 = z + phi, where phi = w.
- GF(2^8) uses y^2 = y + lambda, where lambda = (w+1)z.

The basis-change matrices are not hand-entered. They are derived at elaboration time: the design finds a root of x^8+x^4+x^3+x+1 inside the tower and takes its powers as the columns of the forward matrix, then inverts that matrix by enumeration.

The block is placed between the state register and the row-shift stage of a round datapath. Every lane is independent, so any byte of the output depends only on the byte in the same position of the input.

Top module: `aes_subbytes_layer`

## Requirements
- R1: For every lane, the output byte equals the AES S-box of the input byte. That value is the multiplicative inverse modulo x^8+x^4+x^3+x+1, with zero mapping to zero, followed by the affine transform e_i = d_i ^ d_(i+4) ^ d_(i+5) ^ d_(i+6) ^ d_(i+7) ^ c_i, where indices are taken mod 8 and c = 0x63.
- R2: An input byte of 0x00 yields 0x63, because the inverse of zero is taken as zero.
- R3: An input byte of 0x3d yields 0x27.
- R4: Lane k occupies bits [8k+7:8k] of both the input and the output. Changing one input lane leaves every other output lane unchanged.
- R5: No output byte equals its own input byte, and no output byte equals the bitwise complement of its input byte.
- R6: Over all 256 input values, one lane produces 256 distinct output values, so the substitution is a permutation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| state_i | input | 128 | Input state; lane k is bits [8k+7:8k] |
| state_o | output | 128 | Substituted state, same lane layout |

## Verification
A sweep drives every byte value into every lane at once. Each lane is fed a different offset of the same counter, so all lanes are covered in 256 steps. Comparing the outputs against an exponentiation-based reference separates a wrong basis change or subfield constant, which corrupts most values, from a wrong affine constant or rotation, which shifts every value in the same way.

Uniform states of 0x00 and 0x3d isolate the zero-inverse convention and a single known vector. A one-lane perturbation test exposes miswired lane slices. The permutation check and the fixed-point checks catch inverters that collapse two inputs onto one output.

// File: rtl/sbox_tower_pkg.sv
package sbox_tower_pkg;
  typedef logic [1:0] gf4_t;
  typedef logic [3:0] gf16_t;
  typedef logic [7:0] gf256_t;

  localparam gf16_t  LAMBDA   = 4'b1100;  // (w+1)z
  localparam gf256_t AFFINE_C = 8'h63;
  localparam int     BYTE_W   = 8;

  // GF(2^2), basis {w,1}, w^2 = w + 1
  function automatic gf4_t gf4_mul(gf4_t a, gf4_t b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  function automatic gf4_t gf4_sq(gf4_t a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // multiply by phi = w
  function automatic gf4_t gf4_scl(gf4_t a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // x^-1 = x^2 in GF(4), zero maps to zero
  function automatic gf4_t gf4_inv(gf4_t a);
    return gf4_sq(a);
  endfunction

  // GF(2^4), z^2 = z + phi, three subfield products
  function automatic gf16_t gf16_mul(gf16_t a, gf16_t b);
    gf4_t lo_p, hi_p, mid_p;
    lo_p  = gf4_mul(a[1:0], b[1:0]);
    hi_p  = gf4_mul(a[3:2], b[3:2]);
    mid_p = gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]);
    return {mid_p ^ lo_p, lo_p ^ gf4_scl(hi_p)};
  endfunction

  // lambda * a^2: two squarers, one scaler, one XOR
  function automatic gf16_t gf16_sqscl(gf16_t a);
    gf4_t s1, s0, t;
    s1 = gf4_sq(a[3:2]);
    s0 = gf4_sq(a[1:0]) ^ gf4_scl(s1);
    t  = s1 ^ s0;
    return {t[0], t[1] ^ t[0], s1};
  endfunction

  // GF(2^8) tower product, y^2 = y + lambda (elaboration use)
  function automatic gf256_t tw_mul(gf256_t a, gf256_t b);
    gf16_t lo_p, hi_p, mid_p;
    lo_p  = gf16_mul(a[3:0], b[3:0]);
    hi_p  = gf16_mul(a[7:4], b[7:4]);
    mid_p = gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]);
    return {mid_p ^ lo_p, lo_p ^ gf16_mul(LAMBDA, hi_p)};
  endfunction

  // first tower element that is a root of x^8+x^4+x^3+x+1
  function automatic gf256_t find_root();
    gf256_t p1, p2, p3, p4, p8;
    for (int c = 2; c < 256; c++) begin
      p1 = gf256_t'(c);
      p2 = tw_mul(p1, p1);
      p3 = tw_mul(p2, p1);
      p4 = tw_mul(p2, p2);
      p8 = tw_mul(p4, p4);
      if ((p8 ^ p4 ^ p3 ^ p1 ^ 8'h01) == 8'h00) return p1;
    end
    return 8'h00;
  endfunction

  function automatic gf256_t apply_map(logic [63:0] cols, gf256_t x);
    gf256_t r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (x[i]) r = r ^ cols[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  // column i = root^i
  function automatic logic [63:0] build_fwd();
    logic [63:0] cols;
    gf256_t      rt, p;
    rt = find_root();
    p  = 8'h01;
    cols = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      cols[i*BYTE_W +: BYTE_W] = p;
      p = tw_mul(p, rt);
    end
    return cols;
  endfunction

  // column j = preimage of tower unit vector j
  function automatic logic [63:0] build_bwd(logic [63:0] fwd);
    logic [63:0] cols;
    gf256_t      t;
    cols = '0;
    for (int v = 0; v < 256; v++) begin
      t = apply_map(fwd, gf256_t'(v));
      for (int j = 0; j < BYTE_W; j++)
        if (t == gf256_t'(1 << j)) cols[j*BYTE_W +: BYTE_W] = gf256_t'(v);
    end
    return cols;
  endfunction
endpackage

// File: rtl/gf16_inv.sv
module gf16_inv
  import sbox_tower_pkg::*;
(
  input  logic [3:0] a_i,
  output logic [3:0] y_o
);
  gf4_t hi, lo, sum, delta, dinv;

  always_comb begin
    hi    = a_i[3:2];
    lo    = a_i[1:0];
    sum   = hi ^ lo;
    delta = gf4_scl(gf4_sq(hi)) ^ gf4_mul(sum, lo);
    dinv  = gf4_inv(delta);
    y_o   = {gf4_mul(hi, dinv), gf4_mul(sum, dinv)};
  end

  always_comb begin
    if (!$isunknown(a_i)) begin
      assert_inv16_unity_R1: assert (a_i == 4'h0 || gf16_mul(a_i, y_o) == 4'h1);
      assert_inv16_zero_R2:  assert (a_i != 4'h0 || y_o == 4'h0);
    end
  end
endmodule

// File: rtl/gf256_inv.sv
module gf256_inv
  import sbox_tower_pkg::*;
(
  input  logic [7:0] a_i,
  output logic [7:0] y_o
);
  gf16_t hi, lo, sum, delta, dinv, sq_term;

  always_comb begin
    hi      = a_i[7:4];
    lo      = a_i[3:0];
    sum     = hi ^ lo;
    sq_term = gf16_sqscl(hi);
    delta   = sq_term ^ gf16_mul(sum, lo);
  end

  gf16_inv u_dinv (.a_i(delta), .y_o(dinv));

  assign y_o = {gf16_mul(hi, dinv), gf16_mul(sum, dinv)};

  always_comb begin
    if (!$isunknown(a_i)) begin
      assert_sqscl_match_R1: assert (sq_term == gf16_mul(LAMBDA, gf16_mul(hi, hi)));
      assert_inv256_unity_R1: assert (a_i == 8'h00 || tw_mul(a_i, y_o) == 8'h01);
      assert_inv256_zero_R2:  assert (a_i != 8'h00 || y_o == 8'h00);
    end
  end
endmodule

// File: rtl/sbox_byte.sv
module sbox_byte
  import sbox_tower_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  localparam logic [63:0] FWD_COLS = build_fwd();
  localparam logic [63:0] BWD_COLS = build_bwd(FWD_COLS);

  gf256_t tower_in, tower_inv, std_inv;

  assign tower_in = apply_map(FWD_COLS, byte_i);

  gf256_inv u_inv (.a_i(tower_in), .y_o(tower_inv));

  assign std_inv = apply_map(BWD_COLS, tower_inv);

  for (genvar i = 0; i < BYTE_W; i++) begin : g_affine
    assign byte_o[i] = std_inv[i] ^ std_inv[(i+4)%BYTE_W] ^ std_inv[(i+5)%BYTE_W]
                     ^ std_inv[(i+6)%BYTE_W] ^ std_inv[(i+7)%BYTE_W] ^ AFFINE_C[i];
  end

  always_comb begin
    if (!$isunknown(byte_i)) begin
      assert_no_fixed_pt_R5:  assert (byte_o != byte_i);
      assert_no_anti_fixed_R5: assert (byte_o != ~byte_i);
    end
  end
endmodule

// File: rtl/aes_subbytes_layer.sv
module aes_subbytes_layer #(
  parameter int NUM_LANES = 16
) (
  input  logic [NUM_LANES*8-1:0] state_i,
  output logic [NUM_LANES*8-1:0] state_o
);
  localparam int LANE_W = sbox_tower_pkg::BYTE_W;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    sbox_byte u_sb (
      .byte_i(state_i[k*LANE_W +: LANE_W]),
      .byte_o(state_o[k*LANE_W +: LANE_W])
    );
  end
endmodule

// File: tb/sim_aes_subbytes_layer.sv
module sim_aes_subbytes_layer;
  localparam int LANES = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [LANES*8-1:0] st_in = '0;
  logic [LANES*8-1:0] st_out;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  aes_subbytes_layer #(.NUM_LANES(LANES)) u0 (.state_i(st_in), .state_o(st_out));

  function automatic logic [7:0] xt(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = xt(x);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(logic [7:0] a);
    logic [7:0] r, base, e;
    r = 8'h01; base = a;
    for (int i = 0; i < 8; i++) begin   // a^254
      if (i != 0) r = gmul(r, base);
      base = gmul(base, base);
    end
    e = 8'h63;
    for (int i = 0; i < 8; i++)
      e[i] = e[i] ^ r[i] ^ r[(i+4)%8] ^ r[(i+5)%8] ^ r[(i+6)%8] ^ r[(i+7)%8];
    return e;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_ne(string tag, logic [7:0] act, logic [7:0] bad);
    n_cmp++;
    if (act === bad) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=not %02h", tag, act, bad);
    end
  endtask

  task automatic apply(logic [LANES*8-1:0] v);
    @(posedge clk);
    st_in = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LANES*8-1:0] v, base_out;
    bit seen [256];
    logic [7:0] in_b, out_b;

    // R2: zero state
    apply('0);
    for (int k = 0; k < LANES; k++) chk("R2 zero lane", st_out[k*8 +: 8], 8'h63);

    // R3: uniform 0x3d
    apply({LANES{8'h3d}});
    for (int k = 0; k < LANES; k++) chk("R3 3d lane", st_out[k*8 +: 8], 8'h27);

    // R1: known points
    apply({{(LANES-4){8'h00}}, 8'h53, 8'hff, 8'h01, 8'h10});
    chk("R1 in=10", st_out[7:0],   8'hca);
    chk("R1 in=01", st_out[15:8],  8'h7c);
    chk("R1 in=ff", st_out[23:16], 8'h16);
    chk("R1 in=53", st_out[31:24], 8'hed);

    // R1 R5 R6: full sweep, lanes offset by 17*k
    for (int s = 0; s < 256; s++) seen[s] = 1'b0;
    for (int s = 0; s < 256; s++) begin
      for (int k = 0; k < LANES; k++) v[k*8 +: 8] = 8'((s + 17*k) & 255);
      apply(v);
      for (int k = 0; k < LANES; k++) begin
        in_b  = v[k*8 +: 8];
        out_b = st_out[k*8 +: 8];
        chk("R1 sweep", out_b, ref_sbox(in_b));
        chk_ne("R5 fixed point", out_b, in_b);
        chk_ne("R5 complement point", out_b, ~in_b);
      end
      out_b = st_out[7:0];
      n_cmp++;
      if (seen[out_b]) begin
        n_bad++;
        $display("FAIL R6 repeated output actual=%02h expected=unused value", out_b);
      end
      seen[out_b] = 1'b1;
    end

    // R4: perturb one lane at a time
    for (int k = 0; k < LANES; k++) v[k*8 +: 8] = 8'((k*37 + 11) & 255);
    apply(v);
    base_out = st_out;
    for (int k = 0; k < LANES; k++) begin
      logic [LANES*8-1:0] w;
      w = v;
      w[k*8 +: 8] = w[k*8 +: 8] ^ 8'ha5;
      apply(w);
      for (int m = 0; m < LANES; m++) begin
        if (m == k) chk("R4 changed lane", st_out[m*8 +: 8], ref_sbox(w[m*8 +: 8]));
        else        chk("R4 untouched lane", st_out[m*8 +: 8], base_out[m*8 +: 8]);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule